// File: doc/BRIEF.md
# Bridge interrupt status collector

This block collects error and event indications from the rest of a bus bridge and turns them into a single interrupt line to the local processor. Two kinds of sources arrive as one-cycle pulses: four PCI-side error conditions, and eight local-bus events. Each pulse sets a sticky flag. The PCI error flags sit in the top nibble of a 16-bit status halfword. The local-bus events sit in an 8-bit status byte, beside an 8-bit mask byte.

Software reaches the block through a small register port. Each access is one cycle and carries a register select, a write strobe, two byte-lane strobes and a 16-bit data word. Read data is returned combinationally for the selected register. The two status registers clear in different ways. A PCI error flag clears when a one is written to its position. The local-bus flags all clear together when a zero is written to their byte. The interrupt line is registered. It is high when the global enable is set and at least one local-bus flag is also selected by the mask.

Top module: `brg_irq_collect`

## Requirements
- R1: A synchronous active-low reset clears every status flag, the mask byte and the global enable. The interrupt output goes low, and all three registers read zero.
- R2: A pulse on `pci_err_ev[k]` sets bit 12+k of the PCI status halfword at select 0. Bit 15 is parity error (k=3), bit 14 system error (k=2), bit 13 master abort (k=1) and bit 12 target abort (k=0). Bits 11..0 always read zero.
- R3: A write to select 0 with lane 1 strobed clears each PCI flag whose bit in `reg_wdata[15:12]` is one. Flags written with zero keep their value.
- R4: A pulse on `lb_ev[i]` sets bit i of the local-bus status byte, read at select 1 in bits 7..0. The bits are: 7 mailbox, 6 target read abort, 5 target write abort, 4 PCI pin interrupt, 3 parity error, 2 inbound queue post, 1 DMA channel 1 and 0 DMA channel 0.
- R5: A write to select 1 with lane 0 strobed and `reg_wdata[7:0]` equal to zero clears every local-bus flag. The same write with a non-zero byte leaves the flags unchanged.
- R6: The mask byte is written and read at select 1, bits 15..8, through lane 1. Mask bit i enables local-bus flag i.
- R7: The global enable is bit 10 at select 2 and is written through lane 1. Every other bit at select 2 reads zero, as does every bit at select 3.
- R8: `irq_out` becomes, one clock after the registers change, the value of the global enable AND the OR over i of (flag i AND mask bit i).
- R9: When an event pulse and a clearing write reach the same flag in one cycle, the flag ends that cycle set.
- R10: A flag stays set through any number of further events and through writes that do not clear it.
- R11: A write changes only the byte lanes whose strobe is set. With lane 1 off, a write to select 0 clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 PCI status, 1 local-bus status and mask, 2 control, 3 unused |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_strb | input | 2 | Byte-lane strobes (bit 0 = bits 7..0, bit 1 = bits 15..8) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| pci_err_ev | input | 4 | PCI error pulses (3 parity, 2 system, 1 master abort, 0 target abort) |
| lb_ev | input | 8 | Local-bus event pulses, one per status bit |
| irq_out | output | 1 | Registered interrupt to the local processor |

## Verification
An event pulse can arrive in the same cycle as a software write that clears the flag it targets. This can happen with a one-to-clear write on the PCI halfword or with a zero write on the local-bus byte. The bench provokes both cases by raising the event and the write on the same clock edge. It then reads the register back and expects the flag to be set, while flags that only the write touched have gone clear. The registered interrupt also changes in the cycle after such an edge, so the bench samples it twice: once before the extra register stage has updated and once after.

// File: rtl/brg_irq_pkg.sv
// Package: shared sizes and register selects for the bridge interrupt collector.
// Assumes a 16-bit register port split into byte lanes.
package brg_irq_pkg;
    localparam int SEL_W   = 2;
    localparam int DATA_W  = 16;
    localparam int PCI_N   = 4;
    localparam int PCI_LSB = 12;
    localparam int LB_N    = 8;
    localparam int EN_BIT  = 10;

    typedef enum logic [SEL_W-1:0] {
        SEL_PCI  = 2'd0,
        SEL_LB   = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/brg_sticky_w1c.sv
// Module: bank of sticky flags, each set by a pulse and cleared by its own clear bit.
// Assumes pulses are one cycle wide; set has priority over clear.
module brg_sticky_w1c #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // One flag: reset, then set wins, then per-bit clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[g] <= 1'b0;
            else if (set_i[g])
                flag_o[g] <= 1'b1;
            else if (clr_i[g])
                flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/brg_sticky_bulk.sv
// Module: bank of sticky flags, each set by a pulse, all cleared by one common strobe.
// Assumes pulses are one cycle wide; set has priority over the common clear.
module brg_sticky_bulk #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_all_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // One flag: reset, then set wins, then bulk clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[g] <= 1'b0;
            else if (set_i[g])
                flag_o[g] <= 1'b1;
            else if (clr_all_i)
                flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/brg_irq_gen.sv
// Module: mask and global-enable registers plus the registered interrupt output.
// Assumes flags are already registered; adds one clock of latency to the line.
module brg_irq_gen #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [N-1:0] mask_d,
    input  logic         en_we,
    input  logic         en_d,
    input  logic [N-1:0] flags_i,
    output logic [N-1:0] mask_o,
    output logic         en_o,
    output logic         irq_o
);
    logic hit;

    // Mask register, written whole when its lane is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (mask_we)
            mask_o <= mask_d;
    end

    // Global enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_o <= 1'b0;
        else if (en_we)
            en_o <= en_d;
    end

    // Any enabled flag pending.
    always_comb begin
        hit = |(flags_i & mask_o);
    end

    // Registered interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= en_o & hit;
    end
endmodule

// File: rtl/brg_irq_collect.sv
// Module: top of the bridge interrupt collector. Decodes the register port,
// holds the PCI error flags (one-to-clear) and local-bus flags (zero-write clear),
// and drives the interrupt line. Assumes single-cycle register writes.
module brg_irq_collect
    import brg_irq_pkg::*;
#(
    parameter int SW  = SEL_W,
    parameter int DW  = DATA_W,
    parameter int PN  = PCI_N,
    parameter int PL  = PCI_LSB,
    parameter int LN  = LB_N,
    parameter int ENB = EN_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] reg_sel,
    input  logic          reg_wr,
    input  logic [DW/8-1:0] reg_strb,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [PN-1:0] pci_err_ev,
    input  logic [LN-1:0] lb_ev,
    output logic          irq_out
);
    localparam int SB = DW / 8;

    logic [PN-1:0] pci_flags;
    logic [PN-1:0] pci_clr;
    logic [LN-1:0] lb_flags;
    logic [LN-1:0] mask_q;
    logic          en_q;
    logic          wr_pci, wr_lb, wr_ctl;
    logic          lb_clr_all, mask_we, en_we;

    // Per-register write decode.
    always_comb begin
        wr_pci = reg_wr && (reg_sel == SW'(SEL_PCI));
        wr_lb  = reg_wr && (reg_sel == SW'(SEL_LB));
        wr_ctl = reg_wr && (reg_sel == SW'(SEL_CTL));
    end

    // One-to-clear bits for the PCI flags, gated by their byte lane.
    always_comb begin
        for (int i = 0; i < PN; i++)
            pci_clr[i] = wr_pci && reg_strb[(PL+i)/8] && reg_wdata[PL+i];
    end

    // Zero-write clear of the local-bus byte, mask and enable write strobes.
    always_comb begin
        lb_clr_all = wr_lb && reg_strb[0] && (reg_wdata[LN-1:0] == '0);
        mask_we    = wr_lb && reg_strb[SB-1];
        en_we      = wr_ctl && reg_strb[ENB/8];
    end

    brg_sticky_w1c #(.N(PN)) u_pci (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pci_err_ev),
        .clr_i  (pci_clr),
        .flag_o (pci_flags)
    );

    brg_sticky_bulk #(.N(LN)) u_lb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (lb_ev),
        .clr_all_i (lb_clr_all),
        .flag_o    (lb_flags)
    );

    brg_irq_gen #(.N(LN)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .mask_d  (reg_wdata[DW-1 -: LN]),
        .en_we   (en_we),
        .en_d    (reg_wdata[ENB]),
        .flags_i (lb_flags),
        .mask_o  (mask_q),
        .en_o    (en_q),
        .irq_o   (irq_out)
    );

    // Read multiplexer for the selected register.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SW'(SEL_PCI): reg_rdata[PL +: PN] = pci_flags;
            SW'(SEL_LB): begin
                reg_rdata[LN-1:0]      = lb_flags;
                reg_rdata[DW-1 -: LN]  = mask_q;
            end
            SW'(SEL_CTL): reg_rdata[ENB] = en_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/brg_irq_chk.sv
// Module: assertion checker for the bridge interrupt collector, bound to the top.
module brg_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  reg_sel,
    input logic        reg_wr,
    input logic [1:0]  reg_strb,
    input logic [15:0] reg_wdata,
    input logic [3:0]  pci_err_ev,
    input logic [7:0]  lb_ev,
    input logic        irq_out,
    input logic [3:0]  pci_flags,
    input logic [7:0]  lb_flags,
    input logic [7:0]  mask_q,
    input logic        en_q
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pci_flags == 4'd0 && lb_flags == 8'd0 && mask_q == 8'd0 && !en_q && !irq_out));

    assert_pci_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_err_ev != 4'd0) |=> ((pci_flags & $past(pci_err_ev)) == $past(pci_err_ev)));

    assert_lb_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_ev != 8'd0) |=> ((lb_flags & $past(lb_ev)) == $past(lb_ev)));

    assert_pci_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == 2'd0) |=> ((pci_flags & $past(pci_flags)) == $past(pci_flags)));

    assert_lb_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 && reg_strb[0] && reg_wdata[7:0] == 8'd0 && lb_ev == 8'd0)
        |=> (lb_flags == 8'd0));

    assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(en_q && ((lb_flags & mask_q) != 8'd0))));
endmodule

bind brg_irq_collect brg_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_strb   (reg_strb),
    .reg_wdata  (reg_wdata),
    .pci_err_ev (pci_err_ev),
    .lb_ev      (lb_ev),
    .irq_out    (irq_out),
    .pci_flags  (pci_flags),
    .lb_flags   (lb_flags),
    .mask_q     (mask_q),
    .en_q       (en_q)
);

// File: tb/sim_brg_irq_collect.sv
module sim_brg_irq_collect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_strb = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [3:0]  pci_err_ev = 4'd0;
    logic [7:0]  lb_ev = 8'd0;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    brg_irq_collect u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_strb(reg_strb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pci_err_ev(pci_err_ev), .lb_ev(lb_ev), .irq_out(irq_out)
    );

    // Vector: {lb_ev[7:0], mask[7:0], enable, expected irq}
    localparam int NV = 8;
    localparam logic [17:0] VEC [NV] = '{
        {8'h01, 8'h01, 1'b1, 1'b1},
        {8'h80, 8'h7F, 1'b1, 1'b0},
        {8'h80, 8'h80, 1'b1, 1'b1},
        {8'h24, 8'h20, 1'b1, 1'b1},
        {8'h24, 8'hDB, 1'b1, 1'b0},
        {8'hFF, 8'h00, 1'b1, 1'b0},
        {8'hFF, 8'hFF, 1'b0, 1'b0},
        {8'h10, 8'hFF, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [1:0] st, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; reg_strb = st; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_strb = 2'd0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] d);
        reg_sel = s;
        #2;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] p, input logic [7:0] l);
        @(negedge clk);
        pci_err_ev = p; lb_ev = l;
        @(negedge clk);
        pci_err_ev = 4'd0; lb_ev = 8'd0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, d); check("R1 pci", d, 16'h0000);
        rd(2'd1, d); check("R1 lb/mask", d, 16'h0000);
        rd(2'd2, d); check("R1 ctl", d, 16'h0000);
        check("R1 irq", {15'd0, irq_out}, 16'd0);

        // R8 table walk
        for (int k = 0; k < NV; k++) begin
            wr(2'd1, 2'b11, {VEC[k][9:2], 8'h00});
            wr(2'd2, 2'b10, {5'd0, VEC[k][1], 10'd0});
            pulse(4'd0, VEC[k][17:10]);
            @(negedge clk);
            check($sformatf("R8 vec%0d irq", k), {15'd0, irq_out}, {15'd0, VEC[k][0]});
            rd(2'd1, d);
            check($sformatf("R4 vec%0d lb", k), d, {VEC[k][9:2], VEC[k][17:10]});
        end

        // R8 latency: flag set first, line one clock later
        wr(2'd1, 2'b11, 16'h0100);
        wr(2'd2, 2'b10, 16'h0400);
        @(negedge clk);
        check("R8 idle low", {15'd0, irq_out}, 16'd0);
        pulse(4'd0, 8'h01);
        rd(2'd1, d); check("R4 dma0 flag", d, 16'h0101);
        check("R8 not yet", {15'd0, irq_out}, 16'd0);
        @(negedge clk);
        check("R8 raised", {15'd0, irq_out}, 16'd1);
        // R10 repeat event keeps it set
        pulse(4'd0, 8'h01);
        rd(2'd1, d); check("R10 lb sticky", d, 16'h0101);
        // R5 non-zero write ignored, mask untouched (lane 1 off)
        wr(2'd1, 2'b01, 16'hFF55);
        rd(2'd1, d); check("R5 nonzero ignored", d, 16'h0101);
        // R5 zero write clears, irq drops one clock later
        wr(2'd1, 2'b01, 16'hFF00);
        rd(2'd1, d); check("R5 zero clears", d, 16'h0100);
        @(negedge clk);
        check("R8 dropped", {15'd0, irq_out}, 16'd0);

        // R6 mask readback
        wr(2'd1, 2'b10, 16'hA5FF);
        rd(2'd1, d); check("R6 mask", d, 16'hA500);
        // R7 only enable bit stored
        wr(2'd2, 2'b11, 16'hFFFF);
        rd(2'd2, d); check("R7 ctl set", d, 16'h0400);
        wr(2'd2, 2'b11, 16'h0000);
        rd(2'd2, d); check("R7 ctl clr", d, 16'h0000);
        rd(2'd3, d); check("R7 unused sel", d, 16'h0000);

        // R2 PCI flags
        pulse(4'b1010, 8'd0);
        rd(2'd0, d); check("R2 pci set", d, 16'hA000);
        // R3 one-to-clear
        wr(2'd0, 2'b11, 16'h8000);
        rd(2'd0, d); check("R3 w1c parity", d, 16'h2000);
        // R11 lane 1 not strobed: nothing cleared
        pulse(4'b1111, 8'd0);
        wr(2'd0, 2'b01, 16'hFFFF);
        rd(2'd0, d); check("R11 lane gate", d, 16'hF000);
        // R10 writes of zero keep flags
        wr(2'd0, 2'b11, 16'h0FFF);
        rd(2'd0, d); check("R10 pci hold", d, 16'hF000);

        // R9 event and one-to-clear in the same cycle
        @(negedge clk);
        reg_sel = 2'd0; reg_strb = 2'b10; reg_wdata = 16'hF000; reg_wr = 1'b1;
        pci_err_ev = 4'b1000;
        @(negedge clk);
        reg_wr = 1'b0; reg_strb = 2'd0; pci_err_ev = 4'd0;
        rd(2'd0, d); check("R9 pci event wins", d, 16'h8000);

        // R9 event and zero write on the local-bus byte in the same cycle
        pulse(4'd0, 8'h81);
        @(negedge clk);
        reg_sel = 2'd1; reg_strb = 2'b01; reg_wdata = 16'h0000; reg_wr = 1'b1;
        lb_ev = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0; reg_strb = 2'd0; lb_ev = 8'd0;
        rd(2'd1, d); check("R9 lb event wins", d, 16'hA504);

        // R1 reset mid-run
        wr(2'd2, 2'b10, 16'h0400);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, d); check("R1 pci after rst", d, 16'h0000);
        rd(2'd1, d); check("R1 lb after rst", d, 16'h0000);
        rd(2'd2, d); check("R1 ctl after rst", d, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule